// File: doc/BRIEF.md
# Reference Divider and Phase-Frequency Comparator with Lock Indication

This block is the digital comparison stage of a frequency synthesizer loop. It runs on the crystal oscillator clock, divides that clock by a programmable ratio to make a reference tick, and compares the tick with rising edges of the divided feedback signal. A three-state phase-frequency comparator turns the two event streams into pump-up and pump-down commands for an external charge pump, together with an output enable that releases the pump to high impedance.

A lock indicator idles high and drops low only while a pump command is active, so a settled loop shows a high line broken by short low pulses. A monitor output shows either the reference tick or the feedback edge pulse, chosen by a select input. A polarity input swaps the roles of the two pump outputs for loops with an inverting oscillator. When the power input is low the pump outputs are released and the divider and comparator are held cleared, so the first event after power returns comes from a fresh count.

Top module: `ref_pfd_top`

## Requirements
- R1: With a ratio of N (3 or more), the reference tick repeats every N clock cycles; the first tick after reset or power-up release is seen on `mon_out` (with `mon_sel` = 0) in the sample after the N-th rising clock edge, and the next one N cycles later.
- R2: A ratio of 0, 1 or 2 behaves as a ratio of 3.
- R3: A reference tick arriving while no down command is pending raises the up command in the sample after that tick's edge, and up stays high until a feedback edge arrives.
- R4: A rising edge on `fb_in` raises the down command; at the clock edge where the second of the two commands would be set, both are cleared, so up and down are never high together.
- R5: With `sense_pos` = 1 the up command drives `pump_up` and down drives `pump_dn`; with `sense_pos` = 0 the two are exchanged.
- R6: `lock_ok` is low in every cycle in which `pump_up` or `pump_dn` is high and high in every other cycle.
- R7: While `pwr_on` = 0, `pump_en` is 0, `pump_up` and `pump_dn` are 0 and `lock_ok` is 1.
- R8: After `pwr_on` returns to 1 the divider restarts from zero (first tick after the N-th edge, as in R1), and a feedback level held high across the release produces no down command.
- R9: With `mon_sel` = 1, `mon_out` is high for exactly one sample, the one after the edge that samples a rising edge of `fb_in`.
- R10: While `rst` (synchronous, active high) is asserted the outputs settle to `pump_up` = 0, `pump_dn` = 0, `lock_ok` = 1 and `mon_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on | input | 1 | 1 = normal operation, 0 = powered down |
| ratio | input | 14 | Reference division ratio |
| sense_pos | input | 1 | 1 = normal pump polarity, 0 = swapped |
| mon_sel | input | 1 | Monitor select: 0 = reference tick, 1 = feedback edge |
| fb_in | input | 1 | Divided feedback level |
| pump_up | output | 1 | Pump-up command |
| pump_dn | output | 1 | Pump-down command |
| pump_en | output | 1 | Pump drive enable, 0 = high impedance |
| lock_ok | output | 1 | Lock indicator |
| mon_out | output | 1 | Registered monitor output |

## Verification
The pump commands change at the same edge that samples the triggering event, so they are due one cycle after a feedback edge is driven and N edges after release for the reference; the monitor is registered once and appears at that same edge, while `lock_ok`, `pump_en` and the polarity swap follow combinationally within the cycle. The bench drives inputs and samples outputs on the falling clock edge, counting rising edges from reset or power release, and compares each output at the exact edge index computed from the ratio. The ratio sweep covers every value from 0 to 20 and the maximum 16383.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int RATIO_W_DEF = 14;
    localparam int MIN_RATIO   = 3;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_cmd_t;

    typedef enum logic {
        MON_REF = 1'b0,
        MON_FB  = 1'b1
    } mon_sel_e;

endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int RATIO_W = pfd_pkg::RATIO_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam logic [RATIO_W-1:0] LIM_FLOOR = RATIO_W'(pfd_pkg::MIN_RATIO - 1);

    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] lim;

    always_comb begin
        if (ratio < RATIO_W'(pfd_pkg::MIN_RATIO))
            lim = LIM_FLOOR;
        else
            lim = ratio - 1'b1;
    end

    assign tick = run && (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt >= lim)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

    assert_min_period_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> (cnt != '0));

endmodule

// File: rtl/phase_cmp.sv
module phase_cmp (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                ref_tick,
    input  logic                fb_lvl,
    output logic                fb_pulse,
    output pfd_pkg::pump_cmd_t  cmd
);
    logic fb_q;
    logic nxt_up, nxt_dn;

    // Track the feedback level even while held, so a level that is already
    // high at release does not look like a fresh edge.
    always_ff @(posedge clk) begin
        fb_q <= fb_lvl;
    end

    assign fb_pulse = run && fb_lvl && !fb_q;

    assign nxt_up = cmd.up || ref_tick;
    assign nxt_dn = cmd.dn || fb_pulse;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cmd <= '0;
        end else if (nxt_up && nxt_dn) begin
            cmd <= '0;
        end else begin
            cmd.up <= nxt_up;
            cmd.dn <= nxt_dn;
        end
    end

    assert_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(cmd.up && cmd.dn));

    assert_up_on_ref_R3: assert property (@(posedge clk) disable iff (rst)
        (run && ref_tick && !cmd.dn && !fb_pulse) |=> cmd.up);

    assert_dn_on_fb_R4: assert property (@(posedge clk) disable iff (rst)
        (run && fb_pulse && !cmd.up && !ref_tick) |=> cmd.dn);

endmodule

// File: rtl/lock_mon.sv
module lock_mon (
    input  logic                clk,
    input  logic                rst,
    input  pfd_pkg::pump_cmd_t  cmd,
    input  logic                ref_tick,
    input  logic                fb_pulse,
    input  pfd_pkg::mon_sel_e   sel,
    output logic                lock_ok,
    output logic                mon_out
);
    assign lock_ok = !(cmd.up || cmd.dn);

    always_ff @(posedge clk) begin
        if (rst)
            mon_out <= 1'b0;
        else if (sel == pfd_pkg::MON_FB)
            mon_out <= fb_pulse;
        else
            mon_out <= ref_tick;
    end

    assert_mon_fb_R9: assert property (@(posedge clk) disable iff (rst)
        (sel == pfd_pkg::MON_FB && fb_pulse) |=> mon_out);

endmodule

// File: rtl/ref_pfd_top.sv
module ref_pfd_top #(
    parameter int RATIO_W = pfd_pkg::RATIO_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_on,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               sense_pos,
    input  logic               mon_sel,
    input  logic               fb_in,
    output logic               pump_up,
    output logic               pump_dn,
    output logic               pump_en,
    output logic               lock_ok,
    output logic               mon_out
);
    logic               ref_tick;
    logic               fb_pulse;
    pfd_pkg::pump_cmd_t cmd;
    pfd_pkg::mon_sel_e  sel;

    assign sel = pfd_pkg::mon_sel_e'(mon_sel);

    ref_divider #(.RATIO_W(RATIO_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .run   (pwr_on),
        .ratio (ratio),
        .tick  (ref_tick)
    );

    phase_cmp u_cmp (
        .clk      (clk),
        .rst      (rst),
        .run      (pwr_on),
        .ref_tick (ref_tick),
        .fb_lvl   (fb_in),
        .fb_pulse (fb_pulse),
        .cmd      (cmd)
    );

    lock_mon u_lock (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ref_tick (ref_tick),
        .fb_pulse (fb_pulse),
        .sel      (sel),
        .lock_ok  (lock_ok),
        .mon_out  (mon_out)
    );

    assign pump_en = pwr_on;
    assign pump_up = pwr_on && (sense_pos ? cmd.up : cmd.dn);
    assign pump_dn = pwr_on && (sense_pos ? cmd.dn : cmd.up);

    assert_lock_low_R6: assert property (@(posedge clk) disable iff (rst)
        (pump_up || pump_dn) |-> !lock_ok);

    assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !pwr_on |=> (lock_ok && !mon_out));

    assert_clean_wake_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_on) |-> (!pump_up && !pump_dn && lock_ok));

endmodule

// File: tb/tb_ref_pfd_top.sv
module tb_ref_pfd_top;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_on = 1'b1;
    logic [RW-1:0] ratio = RW'(8);
    logic          sense_pos = 1'b1;
    logic          mon_sel = 1'b0;
    logic          fb_in = 1'b0;
    logic          pump_up, pump_dn, pump_en, lock_ok, mon_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ref_pfd_top #(.RATIO_W(RW)) dut (
        .clk(clk), .rst(rst), .pwr_on(pwr_on), .ratio(ratio),
        .sense_pos(sense_pos), .mon_sel(mon_sel), .fb_in(fb_in),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_en(pump_en),
        .lock_ok(lock_ok), .mon_out(mon_out)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    // Sweep: first two monitor pulses at N and 2N, up rises at N (R1, R2, R3).
    task automatic sweep_ratio(input int r);
        int exp_p;
        int first_hit;
        int second_hit;
        exp_p = (r < 3) ? 3 : r;
        ratio = RW'(r);
        fb_in = 1'b0;
        sense_pos = 1'b1;
        mon_sel = 1'b0;
        do_reset();
        first_hit = 0;
        second_hit = 0;
        for (int n = 1; n <= 2 * exp_p + 1; n++) begin
            step();
            if (mon_out) begin
                if (first_hit == 0) first_hit = n;
                else if (second_hit == 0) second_hit = n;
            end
            if (n == exp_p - 1) check("R3 up before tick", int'(pump_up), 0);
            if (n == exp_p)     check("R3 up at tick", int'(pump_up), 1);
        end
        if (r < 3) begin
            check("R2 clamped first tick", first_hit, exp_p);
            check("R2 clamped period", second_hit - first_hit, exp_p);
        end else begin
            check("R1 first tick", first_hit, exp_p);
            check("R1 period", second_hit - first_hit, exp_p);
        end
        check("R3 up held without feedback", int'(pump_up), 1);
        check("R6 lock low while up", int'(lock_ok), 0);
    endtask

    initial begin
        // Reset state (R10)
        step();
        step();
        check("R10 reset up", int'(pump_up), 0);
        check("R10 reset dn", int'(pump_dn), 0);
        check("R10 reset lock", int'(lock_ok), 1);
        check("R10 reset mon", int'(mon_out), 0);
        check("R7 enable in normal mode", int'(pump_en), 1);

        for (int r = 0; r <= 20; r++) sweep_ratio(r);
        sweep_ratio(16383);

        // Reference leads: up at 8,9, cleared at 10 by feedback (R3, R4, R6)
        ratio = RW'(8); fb_in = 1'b0; sense_pos = 1'b1; mon_sel = 1'b0;
        do_reset();
        for (int n = 1; n <= 11; n++) begin
            step();
            if (n == 7)  check("R3 idle before tick", int'(pump_up), 0);
            if (n == 8 || n == 9) begin
                check("R3 up active", int'(pump_up), 1);
                check("R4 dn idle", int'(pump_dn), 0);
                check("R6 lock low", int'(lock_ok), 0);
            end
            if (n == 9) fb_in = 1'b1;
            if (n == 10 || n == 11) begin
                check("R4 cleared up", int'(pump_up), 0);
                check("R4 cleared dn", int'(pump_dn), 0);
                check("R6 lock high", int'(lock_ok), 1);
            end
        end

        // Feedback leads: dn at 3..7, cleared at 8; monitor shows fb pulse (R4, R9)
        fb_in = 1'b0; mon_sel = 1'b1;
        do_reset();
        for (int n = 1; n <= 9; n++) begin
            step();
            if (n == 2) fb_in = 1'b1;
            if (n >= 3 && n <= 7) begin
                check("R4 dn active", int'(pump_dn), 1);
                check("R4 up idle", int'(pump_up), 0);
                check("R6 lock low on dn", int'(lock_ok), 0);
            end
            if (n == 3) check("R9 fb monitor pulse", int'(mon_out), 1);
            if (n == 4) check("R9 fb monitor single", int'(mon_out), 0);
            if (n == 8) begin
                check("R4 both cleared dn", int'(pump_dn), 0);
                check("R4 both cleared up", int'(pump_up), 0);
                check("R9 ref tick hidden", int'(mon_out), 0);
            end
        end

        // Reversed polarity (R5)
        fb_in = 1'b0; mon_sel = 1'b0; sense_pos = 1'b0;
        do_reset();
        for (int n = 1; n <= 8; n++) step();
        check("R5 swapped dn carries up", int'(pump_dn), 1);
        check("R5 swapped up idle", int'(pump_up), 0);
        fb_in = 1'b1;
        step();
        fb_in = 1'b0;
        do_reset();
        for (int n = 1; n <= 3; n++) step();
        fb_in = 1'b1;
        step();
        check("R5 swapped up carries dn", int'(pump_up), 1);
        check("R5 swapped dn idle", int'(pump_dn), 0);
        sense_pos = 1'b1;

        // Power-down and clean restart (R7, R8)
        ratio = RW'(5); fb_in = 1'b0;
        do_reset();
        for (int n = 1; n <= 6; n++) step();
        fb_in = 1'b1;
        pwr_on = 1'b0;
        for (int n = 1; n <= 4; n++) begin
            step();
            check("R7 pump disabled", int'(pump_en), 0);
            check("R7 up off", int'(pump_up), 0);
            check("R7 dn off", int'(pump_dn), 0);
            check("R7 lock high", int'(lock_ok), 1);
        end
        pwr_on = 1'b1;
        for (int n = 1; n <= 6; n++) begin
            step();
            check("R8 no spurious dn", int'(pump_dn), 0);
            if (n == 4) check("R8 no early tick", int'(mon_out), 0);
            if (n == 5) begin
                check("R8 restart tick", int'(mon_out), 1);
                check("R8 up after restart", int'(pump_up), 1);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule